// File: doc/BRIEF.md
# Conversion-Ready Detector with Fallback Timeout

This block tells a converter sequencer when a single-shot conversion has finished. The sequencer pulses `arm_i` at the end of the serial frame that started the conversion. From that point the block watches the shared data/ready line and runs a worst-case timer at the same time. The line is left high at the end of a frame that reads back the configuration, so its next falling edge means the result is ready. If the line was already low, readiness shows up only as a brief low pulse. The block therefore samples the line on every system clock through a two-flop synchroniser, which catches any low pulse that lasts at least one clock period.

The timer limit depends on the conversion rate. It is the nominal sample period stretched by 10% to cover oscillator tolerance, plus a fixed wake-up allowance. The block computes one limit per rate code from the `CLK_HZ` parameter when it is built. The wait ends on the detected edge or on the timeout, whichever comes first. The block then gives a one-cycle `done_o` pulse and sets `from_edge_o` to show which of the two ended the wait.

Top module: `conv_ready_watch`

## Requirements
- R1: While reset is held and right after it is released, `done_o` and `from_edge_o` are 0.
- R2: `rate_i` selects the sample rate: 0=8, 1=16, 2=32, 3=64, 4=128, 5=250, 6=475, 7=860 SPS. With no qualifying edge, `done_o` is high in the cycle T clocks after the edge that samples `arm_i`. Here T = ceil(CLK_HZ*1.1/SPS) + ceil(CLK_HZ*20e-6), and `from_edge_o` is 0.
- R3: The line may fall while the block is armed and `cs_active_i` is high. If the first clock edge that samples it low comes k+1 edges after the arm edge, `done_o` is high k+3 edges after the arm edge, as long as k+3 <= T. In that case `from_edge_o` is 1.
- R4: Falling edges are ignored while `cs_active_i` is low, and the wait then ends by timeout.
- R5: A falling edge that occurs before arming does not end a later wait. No `done_o` appears without a preceding arm.
- R6: `done_o` lasts exactly one cycle and disarms the block. No further pulse follows until the next arm.
- R7: An arm while waiting restarts the timer. An arm in the cycle that would have produced `done_o` suppresses that pulse.
- R8: The rate code is captured at arm time. Changing `rate_i` during a wait has no effect on it.
- R9: A low pulse on the line only one clock period wide is detected as an edge.
- R10: `from_edge_o` holds its value from the `done_o` pulse until the next arm clears it.
- R11: If the edge and the timeout fall on the same cycle, the edge is reported (`from_edge_o`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle pulse: start a new wait |
| rate_i | input | 3 | Conversion rate code, captured on arm |
| rdy_line_i | input | 1 | Raw data/ready line (asynchronous) |
| cs_active_i | input | 1 | High while the watched converter is selected |
| done_o | output | 1 | One-cycle pulse: conversion finished or timed out |
| from_edge_o | output | 1 | 1 if the last wait ended on the line edge, 0 if on timeout |

## Verification
Every rate code is tried with the line kept high, which separates the eight timeout limits from one another. Edges arrive at chosen and random delays, with chip select both active and inactive, as both steps and one-cycle pulses. These tell edge completion apart from timeout and from ignored edges, and they check the k+3 latency. Directed cases put the edge on the same cycle as the timeout, drop the line before arming, and re-arm both mid-wait and on the final cycle. A rate change during every wait shows that the captured code is the one that counts.

// File: rtl/conv_ready_watch.sv
module conv_ready_watch #(
  parameter int unsigned CLK_HZ     = 250_000_000,
  parameter int unsigned MARGIN_PCT = 10,
  parameter int unsigned WAKE_US    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic [2:0] rate_i,
  input  logic       rdy_line_i,
  input  logic       cs_active_i,
  output logic       done_o,
  output logic       from_edge_o
);

  function automatic longint unsigned sps_of(int c);
    case (c)
      0: return 8;
      1: return 16;
      2: return 32;
      3: return 64;
      4: return 128;
      5: return 250;
      6: return 475;
      default: return 860;
    endcase
  endfunction

  function automatic longint unsigned tmo_cycles(int c);
    longint unsigned num, den, wake;
    num  = longint'(CLK_HZ) * (100 + MARGIN_PCT);
    den  = 100 * sps_of(c);
    wake = (longint'(CLK_HZ) * WAKE_US + 999_999) / 1_000_000;
    return (num + den - 1) / den + wake;
  endfunction

  localparam int CW = $clog2(tmo_cycles(0) + 1);

  logic [CW-1:0] lut [8];
  for (genvar g = 0; g < 8; g++) begin : g_lut
    assign lut[g] = CW'(tmo_cycles(g));
  end

  logic [2:0]    sync;
  logic          armed, done_q, edge_q;
  logic [CW-1:0] cnt, lim;

  wire fall = sync[2] & ~sync[1] & armed & cs_active_i;
  wire hit  = (cnt == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1], sync[0], rdy_line_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      done_q <= 1'b0;
      edge_q <= 1'b0;
      cnt    <= '0;
      lim    <= '0;
    end else begin
      done_q <= 1'b0;
      if (arm_i) begin
        armed  <= 1'b1;
        cnt    <= '0;
        lim    <= lut[rate_i];
        edge_q <= 1'b0;
      end else if (armed) begin
        if (fall || hit) begin
          armed  <= 1'b0;
          done_q <= 1'b1;
          edge_q <= fall;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign done_o      = done_q;
  assign from_edge_o = edge_q;

endmodule

module conv_ready_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic arm_i,
  input logic done_o,
  input logic from_edge_o
);
  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n)      pend <= 1'b0;
    else if (arm_i)  pend <= 1'b1;
    else if (done_o) pend <= 1'b0;
  end

  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  arm_quiets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> !done_o);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(arm_i)) |-> $stable(from_edge_o));

  // R5
  done_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> pend);
endmodule

bind conv_ready_watch conv_ready_watch_chk chk_i (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i),
  .done_o(done_o), .from_edge_o(from_edge_o)
);

// File: tb/conv_ready_watch_tb_top.sv
module conv_ready_watch_tb_top;
  localparam int unsigned TB_HZ = 100_000;

  logic clk = 1'b0, rst_n = 1'b0, arm_i = 1'b0, rdy_line_i = 1'b1, cs_active_i = 1'b1;
  logic [2:0] rate_i = 3'd0;
  logic done_o, from_edge_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  conv_ready_watch #(.CLK_HZ(TB_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .rate_i(rate_i),
    .rdy_line_i(rdy_line_i), .cs_active_i(cs_active_i),
    .done_o(done_o), .from_edge_o(from_edge_o)
  );

  function automatic int exp_t(int code);
    int r;
    longint a, b;
    r = (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 32 : (code == 3) ? 64 :
        (code == 4) ? 128 : (code == 5) ? 250 : (code == 6) ? 475 : 860;
    a = longint'(TB_HZ) * 11;
    b = 10 * longint'(r);
    return int'((a + b - 1) / b + (longint'(TB_HZ) * 20 + 999_999) / 1_000_000);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input int code);
    arm_i = 1'b1;
    rate_i = 3'(code);
    @(posedge clk);
    @(negedge clk);
    arm_i = 1'b0;
  endtask

  task automatic settle();
    rdy_line_i = 1'b1;
    cs_active_i = 1'b1;
    repeat (5) begin @(posedge clk); @(negedge clk); end
  endtask

  // Waits after an arm (called at the negedge after the arm edge).
  // k < 0: no drop. pulse: line low for one cycle only.
  task automatic wait_case(input int code, input int k, input bit pulse, input string req);
    int t, n_exp, n;
    bit fe_exp;
    t = exp_t(code);
    n_exp = (k >= 0 && cs_active_i && k + 3 <= t) ? k + 3 : t;
    fe_exp = (n_exp != t) || (k >= 0 && cs_active_i && k + 3 == t);
    n = -1;
    if (k == 0) rdy_line_i = 1'b0;
    for (int i = 1; i <= t + 3; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 2) rate_i = ~3'(code);       // R8: ignored mid-wait
      if (done_o && n < 0) n = i;
      if (i == k) rdy_line_i = 1'b0;
      if (pulse && i == k + 1) rdy_line_i = 1'b1;
      if (n > 0 && i == n + 1) check(!done_o, "R6 single pulse", int'(done_o), 0);
    end
    check(n == n_exp, req, n, n_exp);
    check(from_edge_o == fe_exp, {req, " source"}, int'(from_edge_o), int'(fe_exp));
    // R10: flag still held later
    repeat (4) begin @(posedge clk); @(negedge clk); end
    check(from_edge_o == fe_exp && !done_o, "R10 flag hold", int'(from_edge_o), int'(fe_exp));
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done_o && !from_edge_o, "R1 reset", int'({done_o, from_edge_o}), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(!done_o && !from_edge_o, "R1 after reset", int'({done_o, from_edge_o}), 0);

    // R2: every rate code times out at its limit
    for (int c = 0; c < 8; c++) begin
      do_arm(c);
      wait_case(c, -1, 1'b0, "R2 timeout");
      settle();
    end

    // R3: edge with chip select active
    do_arm(4); wait_case(4, 10, 1'b0, "R3 edge"); settle();
    do_arm(6); wait_case(6, 0, 1'b0, "R3 edge k0"); settle();

    // R4: chip select inactive
    cs_active_i = 1'b0;
    do_arm(7); wait_case(7, 20, 1'b0, "R4 cs off"); settle();

    // R5: line falls before arm and stays low
    rdy_line_i = 1'b0;
    repeat (5) begin @(posedge clk); @(negedge clk); end
    check(!done_o, "R5 no done unarmed", int'(done_o), 0);
    do_arm(7); wait_case(7, -1, 1'b0, "R5 stale edge"); settle();

    // R9: one-cycle pulse
    do_arm(5); wait_case(5, 30, 1'b1, "R9 narrow pulse"); settle();

    // R11: edge and timeout on the same cycle
    do_arm(7); wait_case(7, exp_t(7) - 3, 1'b0, "R11 tie"); settle();

    // R7: re-arm mid-wait restarts
    do_arm(7);
    for (int i = 1; i <= 60; i++) begin @(posedge clk); @(negedge clk); end
    do_arm(7); wait_case(7, -1, 1'b0, "R7 restart"); settle();

    // R7: arm on the final cycle suppresses the pulse; R10 flag cleared by arm
    do_arm(6); wait_case(6, 5, 1'b0, "R3 pre"); settle();
    do_arm(7);
    check(!from_edge_o, "R10 arm clears flag", int'(from_edge_o), 0);
    for (int i = 1; i <= exp_t(7) - 1; i++) begin @(posedge clk); @(negedge clk); end
    do_arm(7);
    check(!done_o, "R7 suppressed", int'(done_o), 0);
    wait_case(7, -1, 1'b0, "R7 after suppress"); settle();

    // Random mix
    for (int j = 0; j < 20; j++) begin
      int code, k;
      bit p;
      code = 5 + int'($urandom_range(2, 0));
      k = int'($urandom_range(exp_t(code) + 10, 0));
      cs_active_i = ($urandom_range(3, 0) != 0);
      p = $urandom_range(1, 0);
      do_arm(code);
      wait_case(code, k, p, "R3 random");
      settle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule